// File: doc/BRIEF.md
# SIMD saturating rounding shifter

This block is a packed-vector datapath stage. It takes a data vector and a shift vector that are split into lanes of the same size. It moves every data lane by a signed count, and the count comes from the matching lane of the shift vector. The sign of the count chooses the direction for each lane separately. Positive counts shift left. Zero or negative counts shift right, and a right shift rounds to nearest. A left-shift result that does not fit the lane type is clamped to the nearest representable value; it never wraps.

A single operation is presented on `in_valid` together with its lane size, its signedness and its vector width. The result is registered once and appears on the next clock with `out_valid`. A sticky flag gathers every clamping event in the active lanes. It stays set until the control logic pulses `flag_clr`.

Top module: `simd_qrshl`

## Requirements
- R1: The count of each lane is the low 8 bits of the matching lane of `opnd_b`, read as a two's-complement value. A count greater than zero shifts the data lane left by that many bits.
- R2: A count of zero or below shifts the lane right by its magnitude n. Before the shift, 2^(n-1) is added at full precision, so the result is rounded to nearest with ties going upward. A count of exactly zero returns the lane unchanged.
- R3: `size_sel` picks the lane width: 2'b00 selects 8 bits, 2'b01 selects 16, 2'b10 selects 32 and 2'b11 selects 64. Lane k occupies bits [k*W +: W].
- R4: `is_signed`=1 treats the data lanes and the results as two's complement. An overflowing lane then clamps to the largest positive value, or to the most negative value when the input is negative. With `is_signed`=0 the lanes are unsigned, and overflow clamps to all ones.
- R5: A left shift whose exact result lies outside the lane range saturates. Any nonzero input saturates when the count is equal to or larger than the lane width. A zero input never saturates.
- R6: A right shift never saturates. A right shift by more than the lane width gives zero.
- R7: With `wide`=0 only the lower 64 bits form the vector. `out_vec[127:64]` is then zero, and the upper lanes cannot set the sticky flag.
- R8: `sat_sticky` becomes 1 on the clock that registers an operation in which any active lane saturated. It stays 1 until `flag_clr` is sampled high. If a clear and a saturating operation arrive on the same clock, the flag ends up set.
- R9: `out_valid` equals `in_valid` delayed by one clock. `out_vec` loads only when `in_valid` is 1 and otherwise holds its value.
- R10: While `rst_n` is low, `out_valid`, `out_vec` and `sat_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| size_sel | input | 2 | Lane width code |
| is_signed | input | 1 | 1: signed data lanes, 0: unsigned |
| wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| opnd_a | input | 128 | Data vector |
| opnd_b | input | 128 | Shift-count vector |
| out_valid | output | 1 | Registered result valid |
| out_vec | output | 128 | Registered result vector |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
The bench first uses small counts inside each lane width. These separate correct lane slicing from a shifter that leaks bits between neighbouring lanes. Odd values shifted right by one, in both signed and unsigned form, show whether the rounding addend is applied and whether it is applied on the correct side of zero. Counts at and just beyond the lane width, zero inputs with huge counts, and 64-bit mode with overflowing upper lanes test the edges of the saturation logic. Many random operations with counts near the lane width are then compared against an arbitrary-precision model, and these catch mistakes in the clamp direction and in the sticky flag.

// File: rtl/simd_qrshl_pkg.sv
package simd_qrshl_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_B16 = 2'b01,
        LANE_B32 = 2'b10,
        LANE_B64 = 2'b11
    } lane_sz_e;

    localparam int LANE_KINDS = 4;

    // lane width in bits for a lane-size index
    function automatic int lane_bits(input int idx);
        return 8 << idx;
    endfunction

endpackage

// File: rtl/qrs_lane.sv
module qrs_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] din,
    input  logic [7:0]        cnt,
    input  logic              is_signed,
    output logic [LANE_W-1:0] dout,
    output logic              sat
);
    localparam int          XW   = 2 * LANE_W;
    localparam int          RW   = LANE_W + 2;
    localparam logic [8:0]  NMAX = 9'(LANE_W + 1);
    localparam logic [7:0]  WCNT = 8'(LANE_W);

    logic              neg, go_left, ovf;
    logic [XW-1:0]     wide_x, shl;
    logic [8:0]        mag, nclip;
    logic [RW-1:0]     ext, rnd, sum, shr;
    logic [LANE_W-1:0] sat_val;
    logic [1:0]        unused_shr_top;

    always_comb begin
        neg     = is_signed & din[LANE_W-1];
        go_left = !cnt[7] && (cnt != 8'd0);

        // left path: exact product in double width, then range test
        wide_x = {{LANE_W{neg}}, din};
        shl    = wide_x << cnt;
        if (cnt >= WCNT)
            ovf = (din != '0);
        else if (is_signed)
            ovf = (shl[XW-1:LANE_W-1] != {(LANE_W+1){shl[XW-1]}});
        else
            ovf = (shl[XW-1:LANE_W] != '0);

        // right path: rounding add in two extra bits, count clipped
        mag   = 9'd0 - {cnt[7], cnt};
        nclip = (mag > NMAX) ? NMAX : mag;
        ext   = {{2{neg}}, din};
        rnd   = (nclip == 9'd0) ? '0 : (RW'(1) << (nclip - 9'd1));
        sum   = ext + rnd;
        shr   = $signed(sum) >>> nclip;

        sat_val = is_signed ? {neg, {(LANE_W-1){~neg}}} : '1;
        sat     = go_left & ovf;
        dout    = go_left ? (ovf ? sat_val : shl[LANE_W-1:0]) : shr[LANE_W-1:0];
    end

    assign unused_shr_top = shr[RW-1:LANE_W];

endmodule

// File: rtl/qrs_bank.sv
module qrs_bank #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             is_signed,
    input  logic             half_only,
    output logic [VEC_W-1:0] res,
    output logic             sat_any
);
    localparam int NLANE = VEC_W / LANE_W;

    logic [NLANE-1:0] lane_sat;
    logic             unused_b;

    assign unused_b = ^b;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam bit UPPER = (g >= NLANE / 2);
        logic [LANE_W-1:0] raw;
        logic              raw_sat;
        logic              off;

        qrs_lane #(.LANE_W(LANE_W)) u_lane (
            .din       (a[g*LANE_W +: LANE_W]),
            .cnt       (b[g*LANE_W +: 8]),
            .is_signed (is_signed),
            .dout      (raw),
            .sat       (raw_sat)
        );

        assign off                     = half_only && UPPER;
        assign res[g*LANE_W +: LANE_W] = off ? '0 : raw;
        assign lane_sat[g]             = raw_sat & ~off;
    end

    assign sat_any = |lane_sat;

endmodule

// File: rtl/simd_qrshl.sv
module simd_qrshl
    import simd_qrshl_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       size_sel,
    input  logic             is_signed,
    input  logic             wide,
    input  logic             flag_clr,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             sat_sticky
);
    localparam int HALF = VEC_W / 2;

    typedef struct packed {
        logic             valid;
        logic             sticky;
        logic [VEC_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    logic [VEC_W-1:0]      bank_res [LANE_KINDS];
    logic [LANE_KINDS-1:0] bank_sat;
    logic [VEC_W-1:0]      sel_res;
    logic                  sel_sat;

    for (genvar s = 0; s < LANE_KINDS; s++) begin : g_bank
        qrs_bank #(.VEC_W(VEC_W), .LANE_W(lane_bits(s))) u_bank (
            .a         (opnd_a),
            .b         (opnd_b),
            .is_signed (is_signed),
            .half_only (!wide),
            .res       (bank_res[s]),
            .sat_any   (bank_sat[s])
        );
    end

    always_comb begin
        case (lane_sz_e'(size_sel))
            LANE_B8:  begin sel_res = bank_res[0]; sel_sat = bank_sat[0]; end
            LANE_B16: begin sel_res = bank_res[1]; sel_sat = bank_sat[1]; end
            LANE_B32: begin sel_res = bank_res[2]; sel_sat = bank_sat[2]; end
            default:  begin sel_res = bank_res[3]; sel_sat = bank_sat[3]; end
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.valid  = in_valid;
        if (in_valid)
            st_d.res = sel_res;
        st_d.sticky = (flag_clr ? 1'b0 : st_q.sticky) | (in_valid & sel_sat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_vec    = st_q.res;
    assign sat_sticky = st_q.sticky;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));

    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !flag_clr) |=> sat_sticky);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> !sat_sticky);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (out_vec[VEC_W-1:HALF] == '0));

    a_r5_zero_no_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opnd_a == '0 && !sat_sticky) |=> !sat_sticky);

endmodule

// File: tb/simd_qrshl_tb.sv
module simd_qrshl_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   size_sel = 2'b00;
    logic         is_signed = 1'b0;
    logic         wide = 1'b1;
    logic         flag_clr = 1'b0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         sat_sticky;

    int checks = 0;
    int fails  = 0;

    logic [127:0] m_res = '0;
    logic         m_valid = 1'b0;
    logic         m_sticky = 1'b0;

    always #4 clk = ~clk;

    simd_qrshl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .is_signed(is_signed), .wide(wide), .flag_clr(flag_clr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .out_vec(out_vec), .sat_sticky(sat_sticky)
    );

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_lane(input logic [63:0] x, input int w,
                                             input bit sg, input logic [7:0] c,
                                             output bit s);
        logic signed [199:0] v, r, mx, mn;
        int k, n;
        v = 200'(x);
        if (sg && x[w-1]) v = v - (200'sd1 <<< w);
        k = int'($signed(c));
        if (k > 0) r = v <<< k;
        else if (k == 0) r = v;
        else begin
            n = -k;
            r = (v + (200'sd1 <<< (n - 1))) >>> n;
        end
        mx = sg ? (200'sd1 <<< (w - 1)) - 1 : (200'sd1 <<< w) - 1;
        mn = sg ? -(200'sd1 <<< (w - 1)) : 200'sd0;
        s = 1'b0;
        if (r > mx) begin r = mx; s = 1'b1; end
        else if (r < mn) begin r = mn; s = 1'b1; end
        return r[63:0];
    endfunction

    function automatic logic [127:0] ref_vec(input logic [127:0] a, input logic [127:0] b,
                                             input logic [1:0] sz, input bit sg,
                                             input bit wd, output bit anys);
        logic [127:0] msk, o, x;
        logic [63:0]  r;
        bit           s;
        int w, n;
        w   = 8 << sz;
        n   = (wd ? 128 : 64) / w;
        msk = (w == 64) ? 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF : ((128'd1 << w) - 1);
        o    = '0;
        anys = 1'b0;
        for (int j = 0; j < n; j++) begin
            x = (a >> (j * w)) & msk;
            r = ref_lane(x[63:0], w, sg, 8'(b >> (j * w)), s);
            anys |= s;
            o |= ((128'(r)) & msk) << (j * w);
        end
        return o;
    endfunction

    task automatic step(input bit v, input logic [1:0] sz, input bit sg, input bit wd,
                        input bit clr, input logic [127:0] a, input logic [127:0] b,
                        input string tag);
        bit           s;
        logic [127:0] r;
        @(negedge clk);
        in_valid = v; size_sel = sz; is_signed = sg; wide = wd;
        flag_clr = clr; opnd_a = a; opnd_b = b;
        @(posedge clk);
        #1;
        r = ref_vec(a, b, sz, sg, wd, s);
        if (v) m_res = r;
        m_sticky = (clr ? 1'b0 : m_sticky) | (v & s);
        m_valid  = v;
        chk(tag, "out_valid", 128'(out_valid), 128'(m_valid));
        chk(tag, "out_vec", out_vec, m_res);
        chk(tag, "sat_sticky", 128'(sat_sticky), 128'(m_sticky));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [127:0] a, b;
        int w;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "out_valid", 128'(out_valid), 128'd0);
        chk("R10", "out_vec", out_vec, 128'd0);
        chk("R10", "sat_sticky", 128'(sat_sticky), 128'd0);
        rst_n = 1'b1;

        // R1: small left shifts; upper bits of the shift lane ignored
        step(1, 2'b00, 1, 1, 0, {16{8'h03}}, {16{8'h02}}, "R1");
        step(1, 2'b01, 0, 1, 0, {8{16'h0011}}, {8{16'h7F04}}, "R1");
        // R2: rounding right shifts and count zero
        step(1, 2'b00, 0, 1, 0, {16{8'h05}}, {16{8'hFF}}, "R2");
        step(1, 2'b00, 1, 1, 0, {16{8'hFB}}, {16{8'hFF}}, "R2");
        step(1, 2'b01, 1, 1, 0, {8{16'hA5A5}}, {8{16'h0000}}, "R2");
        step(1, 2'b10, 1, 1, 0, {4{32'hFFFF_FFF9}}, {4{32'h0000_00FE}}, "R2");
        // R3: every lane width
        step(1, 2'b10, 0, 1, 0, {4{32'h0001_2345}}, {32'h5, 32'h1, 32'h8, 32'hF}, "R3");
        step(1, 2'b11, 1, 1, 0, {64'h0000_0000_1234_5678, 64'hFFFF_FFFF_FFFF_FF00},
             {64'h20, 64'h4}, "R3");
        // R4: clamp direction, signed and unsigned
        step(1, 2'b00, 1, 1, 1, {8{8'h40, 8'h80}}, {16{8'h01}}, "R4");
        step(1, 2'b00, 0, 1, 1, {8{8'h40, 8'h80}}, {16{8'h01}}, "R4");
        // R5: count at lane width, zero input with huge count
        step(1, 2'b10, 1, 1, 1, {32'h1, 32'h0, 32'hFFFF_FFFF, 32'h0}, {32'h20, 32'h7F, 32'h1F, 32'h1}, "R5");
        step(1, 2'b10, 0, 1, 1, {4{32'h0}}, {4{32'h7F}}, "R5");
        // R6: right shifts at and beyond lane width
        step(1, 2'b11, 0, 1, 1, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {64'hC0, 64'hBF}, "R6");
        step(1, 2'b11, 1, 1, 0, {2{64'h8000_0000_0000_0000}}, {64'h80, 64'hC0}, "R6");
        // R7: narrow mode, upper lanes would saturate
        step(1, 2'b00, 1, 0, 1, {{8{8'h7F}}, {8{8'h01}}}, {16{8'h01}}, "R7");
        step(1, 2'b01, 0, 0, 0, {{4{16'hFFFF}}, {4{16'h0003}}}, {8{16'h0002}}, "R7");
        // R8: set, hold, clear, clear with saturation
        step(1, 2'b00, 1, 1, 0, {16{8'h7F}}, {16{8'h01}}, "R8");
        step(0, 2'b00, 0, 1, 0, '0, '0, "R8");
        step(1, 2'b00, 0, 1, 0, {16{8'h01}}, {16{8'h01}}, "R8");
        step(0, 2'b00, 0, 1, 1, '0, '0, "R8");
        step(1, 2'b00, 1, 1, 1, {16{8'h7F}}, {16{8'h01}}, "R8");
        // R9: result holds while idle
        step(1, 2'b01, 1, 1, 1, {8{16'h1234}}, {8{16'h0001}}, "R9");
        step(0, 2'b11, 0, 1, 0, {2{64'hDEAD}}, {2{64'h5}}, "R9");
        step(0, 2'b00, 1, 0, 0, '1, '1, "R9");

        // random operations, counts mostly near the lane width
        for (int i = 0; i < 600; i++) begin
            logic [1:0] sz;
            sz = 2'($urandom_range(0, 3));
            w  = 8 << sz;
            a  = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 7) == 0) a = a & {16{8'h01}};
            for (int k = 0; k < 16; k++) begin
                if ($urandom_range(0, 3) != 0)
                    b[k*8 +: 8] = 8'($urandom_range(0, 2 * w + 4)) - 8'(w + 2);
                else
                    b[k*8 +: 8] = 8'($urandom);
            end
            step(($urandom_range(0, 5) != 0), sz, $urandom_range(0, 1) != 0,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0, a, b, "R4");
        end

        finish_run();
    end

endmodule